// File: doc/BRIEF.md
# Dual-channel GCI framing interface

This block connects two 8-bit companded voice codecs to one time-division line in the GCI style. Each frame opens with a frame-sync pulse one data-clock period long and carries two B-channel bytes. The data clock runs at twice the bit rate, so every bit occupies two data-clock periods, or four data-clock edges. The first byte of a frame belongs to codec A and the second to codec B. For each codec the block drives a data output with its own enable, which a pad cell turns into a three-state pin. It also deserialises the shared data input and tags each finished byte with its channel.

All line pins are oversampled by a single fast system clock. The mode is set by a strap input: a low level selects this two-channel format. Each codec has a power-down input. When codec A is powered down, the block takes data clock, frame sync and data input from the port-B pins instead of the port-A pins, and codec A's output stays released. When codec B is powered down, its output stays released. Powering down a codec also suppresses its received byte.

The frame sequencer has four states. IDLE waits for a frame. SLOT_A drives codec A's byte. GAP_A is the half period after A's output is released. SLOT_B drives codec B's byte. The transitions are: any state goes to SLOT_A (start, edge count 0) on a rising data-clock edge with frame sync high. SLOT_A goes to GAP_A at frame edge 31. GAP_A goes to SLOT_B at edge 32. SLOT_B goes to IDLE at edge 63. Any state goes to IDLE while the mode strap is high.

Top module: `gci_dual_port`

## Requirements
- R1: While `sel_n` is high, no frame starts, both output enables stay low and `rx_valid` stays low. While it is low, the two-channel framing is active.
- R2: A frame starts (edge count 0) on any rising edge of the selected data clock at which the selected frame sync is high. This includes a rising edge in the middle of a frame, which restarts the frame.
- R3: `a_dout_en` is high from frame edge 0 through edge 30, which is 15.5 data-clock periods. It goes low at edge 31, a falling edge.
- R4: `b_dout_en` is high from frame edge 32 (rising) through edge 62 and goes low at edge 63. After edge 63 the block idles until the next frame sync.
- R5: Data is sent MSB first. Bit k of a slot (k = 0..7) is presented from slot edge 4k, so each bit lasts two data-clock periods. A released output reads 0.
- R6: Both transmit words are latched at the frame start edge. Changing `tx_word_a` or `tx_word_b` later in the frame has no effect on that frame.
- R7: The data input is sampled at slot edges 4k+2 (the second rising edge of each bit), MSB first. After the eighth sample, `rx_word` is presented with `rx_valid` high for exactly one clock. `rx_chan` is 0 for the first slot and 1 for the second.
- R8: While `pwrdn_a` is high, timing and data input come from the port-B pins and the port-A pins are ignored. `a_dout_en` stays low and no channel-0 byte is reported.
- R9: While `pwrdn_b` is high, `b_dout_en` stays low and no channel-1 byte is reported.
- R10: After reset, all outputs are low.
- R11: Line pins are registered once. An output reacts to a data-clock edge two system clocks after the cycle in which the pins changed.
- R12: The two output enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the line |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Mode strap; low selects two-channel framing |
| pwrdn_a | input | 1 | Codec A power-down; moves timing to port B |
| pwrdn_b | input | 1 | Codec B power-down |
| a_dcl | input | 1 | Port-A data clock |
| a_fsc | input | 1 | Port-A frame sync |
| a_din | input | 1 | Port-A serial data input |
| b_dcl | input | 1 | Port-B data clock |
| b_fsc | input | 1 | Port-B frame sync |
| b_din | input | 1 | Port-B serial data input |
| tx_word_a | input | WORD_W | Byte sent in codec A's slot |
| tx_word_b | input | WORD_W | Byte sent in codec B's slot |
| a_dout | output | 1 | Codec A serial data |
| a_dout_en | output | 1 | Codec A output drive enable |
| b_dout | output | 1 | Codec B serial data |
| b_dout_en | output | 1 | Codec B output drive enable |
| rx_word | output | WORD_W | Last received byte |
| rx_valid | output | 1 | One-clock strobe for `rx_word` |
| rx_chan | output | 1 | Channel of `rx_word` (0 = first slot) |

## Verification
The checks assume that each level of the data clock lasts at least two system clocks. They also assume that frame sync and data input change only together with a data-clock edge, never between edges. The power-down and strap inputs are assumed to change only between frames, while the selected data clock and frame sync are both low, so that switching the source cannot create a false rising edge. The stimulus holds every data-clock level for four system clocks and changes data only at bit starts. It toggles the power-down and strap inputs only in idle gaps after both clocks and syncs have been parked low. The unused port is driven with garbage only while it is deselected.

// File: rtl/gci_pkg.sv
package gci_pkg;

    // Data-clock edges per bit: two full periods, each with a rise and a fall.
    localparam int EDGES_PER_BIT = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SLOT_A = 2'd1,
        ST_GAP_A  = 2'd2,
        ST_SLOT_B = 2'd3
    } frame_state_e;

endpackage

// File: rtl/gci_pin_sampler.sv
module gci_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic pwrdn_a,
    input  logic pwrdn_b,
    input  logic a_dcl,
    input  logic a_fsc,
    input  logic a_din,
    input  logic b_dcl,
    input  logic b_fsc,
    input  logic b_din,
    output logic mode_on,
    output logic pd_a_q,
    output logic pd_b_q,
    output logic dcl_rise,
    output logic dcl_edge,
    output logic fsc_q,
    output logic din_q
);

    logic dcl_q;
    logic dcl_d;

    // Port selection happens before the sampling register, so the edge
    // detector only ever sees the pins of the codec that owns timing.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_on <= 1'b0;
            pd_a_q  <= 1'b0;
            pd_b_q  <= 1'b0;
            dcl_q   <= 1'b0;
            dcl_d   <= 1'b0;
            fsc_q   <= 1'b0;
            din_q   <= 1'b0;
        end else begin
            mode_on <= ~sel_n;
            pd_a_q  <= pwrdn_a;
            pd_b_q  <= pwrdn_b;
            dcl_q   <= pwrdn_a ? b_dcl : a_dcl;
            fsc_q   <= pwrdn_a ? b_fsc : a_fsc;
            din_q   <= pwrdn_a ? b_din : a_din;
            dcl_d   <= dcl_q;
        end
    end

    assign dcl_rise = dcl_q & ~dcl_d;
    assign dcl_edge = dcl_q ^ dcl_d;

endmodule

// File: rtl/gci_frame_fsm.sv
module gci_frame_fsm
    import gci_pkg::*;
#(
    parameter int WORD_W = 8,
    localparam int SLOT_EDGES  = WORD_W * EDGES_PER_BIT,
    localparam int FRAME_EDGES = 2 * SLOT_EDGES,
    localparam int CNT_W       = $clog2(FRAME_EDGES),
    localparam int SLOT_W      = $clog2(SLOT_EDGES),
    localparam int BIT_W       = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_on,
    input  logic             dcl_rise,
    input  logic             dcl_edge,
    input  logic             fsc_q,
    output logic             start,
    output logic             cap,
    output logic             cap_last,
    output logic             cap_chan,
    output logic [1:0]       slot_act,
    output logic [BIT_W-1:0] bit_idx
);

    frame_state_e     state;
    frame_state_e     state_n;
    logic [CNT_W-1:0] fc;
    logic [CNT_W-1:0] fc_n;
    logic [CNT_W-1:0] fc_inc;

    assign start  = mode_on & dcl_rise & fsc_q;
    assign fc_inc = fc + 1'b1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            fc    <= '0;
        end else begin
            state <= state_n;
            fc    <= fc_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state;
        fc_n    = fc;
        if (!mode_on) begin
            state_n = ST_IDLE;
            fc_n    = '0;
        end else if (start) begin
            state_n = ST_SLOT_A;
            fc_n    = '0;
        end else if (dcl_edge) begin
            unique case (state)
                ST_IDLE: begin
                    fc_n = '0;
                end
                ST_SLOT_A: begin
                    fc_n = fc_inc;
                    if (fc_inc == CNT_W'(SLOT_EDGES - 1))
                        state_n = ST_GAP_A;
                end
                ST_GAP_A: begin
                    fc_n = fc_inc;
                    if (fc_inc == CNT_W'(SLOT_EDGES))
                        state_n = ST_SLOT_B;
                end
                ST_SLOT_B: begin
                    fc_n = fc_inc;
                    if (fc_inc == CNT_W'(FRAME_EDGES - 1)) begin
                        state_n = ST_IDLE;
                        fc_n    = '0;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        slot_act = 2'b00;
        unique case (state)
            ST_IDLE:   slot_act = 2'b00;
            ST_SLOT_A: slot_act = 2'b01;
            ST_GAP_A:  slot_act = 2'b00;
            ST_SLOT_B: slot_act = 2'b10;
        endcase
        bit_idx  = fc[SLOT_W-1:2];
        cap      = mode_on & dcl_edge & ~start & (state != ST_IDLE)
                   & (fc_inc[1:0] == 2'd2);
        cap_last = cap & (fc_inc[SLOT_W-1:0] == SLOT_W'(SLOT_EDGES - 2));
        cap_chan = fc_inc[SLOT_W];
    end

endmodule

// File: rtl/gci_tx_lane.sv
module gci_tx_lane #(
    parameter int WORD_W = 8,
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              active,
    input  logic              drive_ok,
    input  logic [BIT_W-1:0]  bit_idx,
    output logic              dout,
    output logic              dout_en
);

    localparam logic [BIT_W-1:0] MSB_IDX = BIT_W'(WORD_W - 1);

    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word_q <= '0;
        else if (load)
            word_q <= word_in;
    end

    always_comb begin
        dout_en = active & drive_ok;
        dout    = dout_en & word_q[MSB_IDX - bit_idx];
    end

endmodule

// File: rtl/gci_rx_deframer.sv
module gci_rx_deframer #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              cap_last,
    input  logic              cap_chan,
    input  logic              din_q,
    input  logic              pd_a_q,
    input  logic              pd_b_q,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              rx_chan
);

    logic [WORD_W-1:0] shreg;
    logic              chan_dead;

    assign chan_dead = cap_chan ? pd_b_q : pd_a_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
            rx_chan  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (cap)
                shreg <= {shreg[WORD_W-2:0], din_q};
            if (cap_last && !chan_dead) begin
                rx_word  <= {shreg[WORD_W-2:0], din_q};
                rx_valid <= 1'b1;
                rx_chan  <= cap_chan;
            end
        end
    end

endmodule

// File: rtl/gci_dual_port.sv
module gci_dual_port #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              pwrdn_a,
    input  logic              pwrdn_b,
    input  logic              a_dcl,
    input  logic              a_fsc,
    input  logic              a_din,
    input  logic              b_dcl,
    input  logic              b_fsc,
    input  logic              b_din,
    input  logic [WORD_W-1:0] tx_word_a,
    input  logic [WORD_W-1:0] tx_word_b,
    output logic              a_dout,
    output logic              a_dout_en,
    output logic              b_dout,
    output logic              b_dout_en,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              rx_chan
);

    localparam int BIT_W   = $clog2(WORD_W);
    localparam int N_LANES = 2;

    logic             mode_on, pd_a_q, pd_b_q;
    logic             dcl_rise, dcl_edge, fsc_q, din_q;
    logic             start, cap, cap_last, cap_chan;
    logic [1:0]       slot_act;
    logic [BIT_W-1:0] bit_idx;

    logic [WORD_W-1:0] lane_word [N_LANES];
    logic [N_LANES-1:0] lane_pd;
    logic [N_LANES-1:0] lane_dout;
    logic [N_LANES-1:0] lane_en;

    gci_pin_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .pwrdn_a  (pwrdn_a),
        .pwrdn_b  (pwrdn_b),
        .a_dcl    (a_dcl),
        .a_fsc    (a_fsc),
        .a_din    (a_din),
        .b_dcl    (b_dcl),
        .b_fsc    (b_fsc),
        .b_din    (b_din),
        .mode_on  (mode_on),
        .pd_a_q   (pd_a_q),
        .pd_b_q   (pd_b_q),
        .dcl_rise (dcl_rise),
        .dcl_edge (dcl_edge),
        .fsc_q    (fsc_q),
        .din_q    (din_q)
    );

    gci_frame_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_on  (mode_on),
        .dcl_rise (dcl_rise),
        .dcl_edge (dcl_edge),
        .fsc_q    (fsc_q),
        .start    (start),
        .cap      (cap),
        .cap_last (cap_last),
        .cap_chan (cap_chan),
        .slot_act (slot_act),
        .bit_idx  (bit_idx)
    );

    assign lane_word[0] = tx_word_a;
    assign lane_word[1] = tx_word_b;
    assign lane_pd      = {pd_b_q, pd_a_q};

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        gci_tx_lane #(.WORD_W(WORD_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (start),
            .word_in  (lane_word[i]),
            .active   (slot_act[i]),
            .drive_ok (mode_on & ~lane_pd[i]),
            .bit_idx  (bit_idx),
            .dout     (lane_dout[i]),
            .dout_en  (lane_en[i])
        );
    end

    gci_rx_deframer #(.WORD_W(WORD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .cap_last (cap_last),
        .cap_chan (cap_chan),
        .din_q    (din_q),
        .pd_a_q   (pd_a_q),
        .pd_b_q   (pd_b_q),
        .rx_word  (rx_word),
        .rx_valid (rx_valid),
        .rx_chan  (rx_chan)
    );

    assign a_dout    = lane_dout[0];
    assign a_dout_en = lane_en[0];
    assign b_dout    = lane_dout[1];
    assign b_dout_en = lane_en[1];

endmodule

// File: rtl/gci_dual_port_chk.sv
module gci_dual_port_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_n,
    input logic pwrdn_a,
    input logic pwrdn_b,
    input logic a_dout,
    input logic a_dout_en,
    input logic b_dout,
    input logic b_dout_en,
    input logic rx_valid
);

    AST_SLOTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(a_dout_en && b_dout_en)); // R12
    AST_A_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !a_dout_en |-> !a_dout); // R5
    AST_B_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !b_dout_en |-> !b_dout); // R5
    AST_A_PWRDN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (pwrdn_a && $past(pwrdn_a)) |-> !a_dout_en); // R8
    AST_B_PWRDN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (pwrdn_b && $past(pwrdn_b)) |-> !b_dout_en); // R9
    AST_STRAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (sel_n && $past(sel_n) && $past(sel_n, 2)) |-> (!a_dout_en && !b_dout_en && !rx_valid)); // R1
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R7

endmodule

bind gci_dual_port gci_dual_port_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .pwrdn_a   (pwrdn_a),
    .pwrdn_b   (pwrdn_b),
    .a_dout    (a_dout),
    .a_dout_en (a_dout_en),
    .b_dout    (b_dout),
    .b_dout_en (b_dout_en),
    .rx_valid  (rx_valid)
);

// File: tb/test_gci_dual_port.sv
module test_gci_dual_port;

    localparam int HALF = 4;  // system clocks per data-clock level

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b0, pwrdn_a = 1'b0, pwrdn_b = 1'b0;
    logic a_dcl = 1'b0, a_fsc = 1'b0, a_din = 1'b0;
    logic b_dcl = 1'b0, b_fsc = 1'b0, b_din = 1'b0;
    logic [7:0] tx_word_a = 8'h00, tx_word_b = 8'h00;
    logic a_dout, a_dout_en, b_dout, b_dout_en, rx_valid, rx_chan;
    logic [7:0] rx_word;

    always #5 clk = ~clk;

    gci_dual_port #(.WORD_W(8)) i_gci_dual_port (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n),
        .pwrdn_a(pwrdn_a), .pwrdn_b(pwrdn_b),
        .a_dcl(a_dcl), .a_fsc(a_fsc), .a_din(a_din),
        .b_dcl(b_dcl), .b_fsc(b_fsc), .b_din(b_din),
        .tx_word_a(tx_word_a), .tx_word_b(tx_word_b),
        .a_dout(a_dout), .a_dout_en(a_dout_en),
        .b_dout(b_dout), .b_dout_en(b_dout_en),
        .rx_word(rx_word), .rx_valid(rx_valid), .rx_chan(rx_chan)
    );

    typedef struct packed {
        logic       en_a;
        logic       d_a;
        logic       en_b;
        logic       d_b;
        logic       valid;
        logic       chan;
        logic [7:0] word;
    } exp_t;

    exp_t  m_cur = '0, h0 = '0, h1 = '0;
    int    n_run = 0, n_fail = 0;
    bit    done = 1'b0;
    string phase = "R10 reset";

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", req, phase, act, exp, $time);
        end
    endtask

    // Reference pipeline: R11, outputs reflect pins two clocks later.
    task automatic step();
        h0 = m_cur;
        m_cur.valid = 1'b0;
        @(negedge clk);
        check(a_dout_en === h1.en_a, "R3", a_dout_en, h1.en_a);
        check(a_dout    === h1.d_a,  "R5", a_dout,    h1.d_a);
        check(b_dout_en === h1.en_b, "R4", b_dout_en, h1.en_b);
        check(b_dout    === h1.d_b,  "R5", b_dout,    h1.d_b);
        check(rx_valid  === h1.valid, "R7", rx_valid, h1.valid);
        check(!(a_dout_en && b_dout_en), "R12", {a_dout_en, b_dout_en}, 0);
        if (h1.valid) begin
            check(rx_word === h1.word, "R7", rx_word, h1.word);
            check(rx_chan === h1.chan, "R7", rx_chan, h1.chan);
        end
        h1 = h0;
    endtask

    function automatic exp_t expect_edge(int e, logic [7:0] ta, logic [7:0] tb,
                                         logic [7:0] ra, logic [7:0] rb);
        exp_t x = '0;
        if (sel_n) return x;
        if (!pwrdn_a && e <= 30) begin
            x.en_a = 1'b1;
            x.d_a  = ta[7 - e/4];
        end
        if (!pwrdn_b && e >= 32 && e <= 62) begin
            x.en_b = 1'b1;
            x.d_b  = tb[7 - (e-32)/4];
        end
        if (e == 30 && !pwrdn_a) begin
            x.valid = 1'b1; x.word = ra; x.chan = 1'b0;
        end
        if (e == 62 && !pwrdn_b) begin
            x.valid = 1'b1; x.word = rb; x.chan = 1'b1;
        end
        return x;
    endfunction

    task automatic set_line(input logic dcl, input logic fsc, input logic din);
        if (pwrdn_a) begin b_dcl = dcl; b_fsc = fsc; b_din = din; end
        else begin a_dcl = dcl; a_fsc = fsc; a_din = din; end
    endtask

    task automatic drive_frame(input int n_edges, input logic [7:0] ta, input logic [7:0] tb,
                               input logic [7:0] ra, input logic [7:0] rb, input bit garble);
        logic din_v;
        logic fsc_v;
        tx_word_a = ta;
        tx_word_b = tb;
        din_v = 1'b0;
        set_line(1'b0, 1'b1, din_v);
        repeat (HALF) step();
        for (int e = 0; e < n_edges; e++) begin
            fsc_v = (e == 0);
            if (e % 4 == 0)
                din_v = (e < 32) ? ra[7 - e/4] : rb[7 - (e-32)/4];
            set_line((e % 2) == 0, fsc_v, din_v);
            if (pwrdn_a) begin
                // R8: port-A pins carry junk that must be ignored.
                a_dcl = (e % 2) != 0;
                a_fsc = 1'b1;
                a_din = ~din_v;
            end
            if (garble && e == 2) begin
                // R6: words change after the start edge.
                tx_word_a = ~ta;
                tx_word_b = ~tb;
            end
            m_cur = expect_edge(e, ta, tb, ra, rb);
            repeat (HALF) step();
        end
        if (pwrdn_a) begin a_dcl = 1'b0; a_fsc = 1'b0; a_din = 1'b0; end
    endtask

    task automatic idle_edges(input int n);
        for (int e = 0; e < n; e++) begin
            set_line((e % 2) == 0, 1'b0, e[1]);
            m_cur = '0;
            repeat (HALF) step();
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(a_dout_en === 1'b0 && b_dout_en === 1'b0, "R10", {a_dout_en, b_dout_en}, 0);
        check(a_dout === 1'b0 && b_dout === 1'b0, "R10", {a_dout, b_dout}, 0);
        check(rx_valid === 1'b0 && rx_word === 8'h00, "R10", {rx_valid, rx_word}, 0);
        repeat (3) step();

        phase = "R11 normal";
        drive_frame(64, 8'hA5, 8'h3C, 8'h96, 8'hE1, 1'b0);
        idle_edges(4);

        phase = "R6 latch";
        drive_frame(64, 8'h0F, 8'hF0, 8'h5A, 8'hC3, 1'b1);
        idle_edges(4);

        phase = "R9 pwrdn_b";
        pwrdn_b = 1'b1;
        repeat (4) step();
        drive_frame(64, 8'h81, 8'h7E, 8'h24, 8'hDB, 1'b0);
        idle_edges(2);
        pwrdn_b = 1'b0;
        repeat (4) step();

        phase = "R8 failover";
        pwrdn_a = 1'b1;
        repeat (4) step();
        drive_frame(64, 8'h55, 8'hAA, 8'h33, 8'hCC, 1'b0);
        idle_edges(2);
        pwrdn_a = 1'b0;
        repeat (4) step();

        phase = "R2 restart";
        drive_frame(40, 8'hC6, 8'h39, 8'h71, 8'h8E, 1'b0);
        drive_frame(64, 8'h12, 8'hED, 8'h48, 8'hB7, 1'b0);
        idle_edges(4);

        phase = "R1 strap";
        sel_n = 1'b1;
        repeat (4) step();
        drive_frame(64, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0);
        idle_edges(2);
        sel_n = 1'b0;
        repeat (4) step();

        phase = "R5 pattern";
        drive_frame(64, 8'hFF, 8'h00, 8'h01, 8'h80, 1'b0);
        idle_edges(4);
        repeat (4) step();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog [%s] actual=hung expected=finished", phase);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule